// File: doc/BRIEF.md
# Pseudo-Random Measurement Accumulator Bank

The block compresses a stream of digitized signal samples by projecting each frame of samples onto a set of pseudo-random rows. It has a bank of parallel channels, and each channel keeps one running sum. For every valid sample, each enabled channel folds the sample into its sum. The sign or weight comes from a matrix bit produced on the fly by a single shared linear feedback shift register. When the programmed number of samples has been taken, the bank captures every channel sum into an output shift stage. It clears the accumulators and restarts the generator from a fixed seed. A receiver can therefore rebuild the same matrix.

The captured measurements leave one per cycle in ascending channel order. Only enabled channels are sent. Each word is tagged with its channel index, and the last one carries an end flag. Software lowers the compression rate, and the power, by clearing enable bits. A disabled channel neither updates its sum nor appears in the output.

Top module: `cs_accum_bank`

## Requirements
- R1: In signed mode (`mix_binary`=0), a matrix bit of 1 adds the sample to the channel sum and a bit of 0 subtracts it. Samples are SAMPLE_W-bit two's complement.
- R2: In binary mode (`mix_binary`=1), a matrix bit of 1 adds the sample and a bit of 0 leaves the sum unchanged.
- R3: Sums are ACC_W-bit two's complement. Any frame of at most 2^(ACC_W-SAMPLE_W)-1 samples yields the exact sum with no wrap. `frame_len` is never 0.
- R4: A channel whose `ch_enable` bit is 0 during a sample ignores that sample. A channel whose bit is 0 at the closing sample emits no output word.
- R5: The generator is a 16-bit shift register that shifts left. The feedback bit is s[15]^s[13]^s[12]^s[10], and it becomes the new bit 0. For each valid sample the generator steps NUM_CH times, and channel c uses the feedback bit of step c+1. This holds whatever the enable mask is.
- R6: The generator holds the seed SEED (default 16'hACE1) after reset. It reloads SEED after every closing sample, so every frame uses the same matrix.
- R7: The frame closes on the `frame_len`-th valid sample. From the next cycle, one enabled channel is presented per cycle in ascending channel order, with `meas_chan` giving its index. The sequence completes within NUM_CH cycles.
- R8: `meas_last` is high only with the final enabled channel of a frame.
- R9: All accumulators are zero after a frame closes, so the next frame starts from zero.
- R10: Reset aborts any partial frame and clears the sums and the sample count. While reset is held and in the cycle after it, no measurement word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | SAMPLE_W | Two's-complement sample |
| frame_len | input | ACC_W-SAMPLE_W | Samples per frame (1 to 2^(ACC_W-SAMPLE_W)-1) |
| ch_enable | input | NUM_CH | Per-channel enable mask |
| mix_binary | input | 1 | 0: add/subtract mixing, 1: add/hold mixing |
| meas_valid | output | 1 | Measurement word present |
| meas_data | output | ACC_W | Two's-complement measurement |
| meas_chan | output | clog2(NUM_CH) | Channel index of the word |
| meas_last | output | 1 | Final word of the frame |

## Verification
Frames of all-maximum and all-minimum samples drive the sums to their widest magnitude. These frames show whether sign extension is correct and whether the word is wide enough. Arithmetic ramps make each channel's sum depend on its own matrix bits. They separate a wrong feedback tap, a wrong bit-to-channel order or a missing reseed from correct mixing, in both mixing modes. Sparse masks, a mask changed inside a frame and an all-zero mask show whether gating affects both the update and the output order. A one-sample frame and a reset during a frame probe the frame boundaries.

// File: rtl/cs_accum_pkg.sv
`timescale 1ns/1ps
package cs_accum_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED_DEF = 16'hACE1;

    typedef logic [LFSR_W-1:0] lfsr_state_t;

    typedef enum logic {
        MIX_PLUS_MINUS = 1'b0,
        MIX_ZERO_ONE   = 1'b1
    } mix_mode_e;

    typedef struct packed {
        logic step;   // a valid sample is folded in this cycle
        logic close;  // this sample ends the frame
    } frame_evt_t;

    // one generator step: taps 16,14,13,11, feedback enters at bit 0
    function automatic lfsr_state_t lfsr_advance(input lfsr_state_t s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[LFSR_W-2:0], fb};
    endfunction

endpackage

// File: rtl/cs_frame_ctrl.sv
`timescale 1ns/1ps
module cs_frame_ctrl
    import cs_accum_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [LEN_W-1:0] frame_len,
    output frame_evt_t       evt
);

    logic [LEN_W-1:0] taken_q;
    logic [LEN_W:0]   taken_inc;

    assign taken_inc = {1'b0, taken_q} + (LEN_W+1)'(1);

    always_comb begin
        evt.step  = smp_valid;
        evt.close = smp_valid && (taken_inc >= {1'b0, frame_len});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= '0;
        end else if (evt.close) begin
            taken_q <= '0;
        end else if (evt.step) begin
            taken_q <= taken_inc[LEN_W-1:0];
        end
    end

    // R3: a zero-length frame is outside the supported range
    a_r3_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (frame_len != '0));

    // R7: the count never runs past the programmed length
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !evt.close) |=> (taken_q != '0));

endmodule

// File: rtl/cs_lfsr_bank.sv
`timescale 1ns/1ps
module cs_lfsr_bank
    import cs_accum_pkg::*;
#(
    parameter int          NUM_CH = 25,
    parameter lfsr_state_t SEED   = LFSR_SEED_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_evt_t        evt,
    output logic [NUM_CH-1:0] mix_bits
);

    lfsr_state_t state_q;
    lfsr_state_t chain [NUM_CH+1];

    assign chain[0] = state_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_step
        assign chain[c+1]  = lfsr_advance(chain[c]);
        assign mix_bits[c] = chain[c+1][0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (evt.close) begin
            state_q <= SEED;
        end else if (evt.step) begin
            state_q <= chain[NUM_CH];
        end
    end

    // R5: the generator never falls into the all-zero lock-up state
    a_r5_state_live: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R6: a closing sample leaves the seed for the next frame
    a_r6_reseed: assert property (@(posedge clk) disable iff (rst)
        evt.close |=> (state_q == SEED));

endmodule

// File: rtl/cs_accum_channel.sv
`timescale 1ns/1ps
module cs_accum_channel
    import cs_accum_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int ACC_W    = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  frame_evt_t              evt,
    input  logic                    enable,
    input  logic                    mix_bit,
    input  mix_mode_e               mode,
    input  logic [SAMPLE_W-1:0]     sample,
    output logic signed [ACC_W-1:0] sum_next
);

    localparam int EXT_W = ACC_W - SAMPLE_W;

    logic signed [ACC_W-1:0] sum_q;
    logic signed [ACC_W-1:0] smp_ext;
    logic signed [ACC_W-1:0] addend;
    logic                    update;

    assign smp_ext = {{EXT_W{sample[SAMPLE_W-1]}}, sample};
    assign update  = evt.step && enable;

    always_comb begin
        unique case (mode)
            MIX_ZERO_ONE:   addend = mix_bit ? smp_ext : '0;
            default:        addend = mix_bit ? smp_ext : -smp_ext;
        endcase
        sum_next = update ? (sum_q + addend) : sum_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else if (evt.close) begin
            sum_q <= '0;
        end else if (update) begin
            sum_q <= sum_next;
        end
    end

    // R3: signed accumulation must not wrap within a supported frame
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (update && (addend[ACC_W-1] == sum_q[ACC_W-1]))
            |-> (sum_next[ACC_W-1] == sum_q[ACC_W-1]));

    // R4: a gated channel keeps its sum
    a_r4_gated_hold: assert property (@(posedge clk) disable iff (rst)
        (!evt.close && !update) |=> $stable(sum_q));

    // R2: a zero entry in binary mode holds the sum
    a_r2_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (update && !evt.close && mode == MIX_ZERO_ONE && !mix_bit) |=> $stable(sum_q));

    // R9: a closed frame leaves a cleared accumulator
    a_r9_cleared: assert property (@(posedge clk) disable iff (rst)
        evt.close |=> (sum_q == '0));

endmodule

// File: rtl/cs_meas_serializer.sv
`timescale 1ns/1ps
module cs_meas_serializer
    import cs_accum_pkg::*;
#(
    parameter int NUM_CH = 25,
    parameter int ACC_W  = 13,
    parameter int CH_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [NUM_CH-1:0]       load_mask,
    input  logic signed [ACC_W-1:0] load_sums [NUM_CH],
    output logic                    meas_valid,
    output logic [ACC_W-1:0]        meas_data,
    output logic [CH_W-1:0]         meas_chan,
    output logic                    meas_last
);

    localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NUM_CH - 1);

    logic signed [ACC_W-1:0] slot_q [NUM_CH];
    logic [NUM_CH-1:0]       mask_q;
    logic [CH_W-1:0]         idx_q;
    logic                    busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            mask_q <= load_mask;
        end else if (busy_q) begin
            mask_q <= mask_q >> 1;
            idx_q  <= idx_q + CH_W'(1);
            if (idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        if (c == NUM_CH - 1) begin : g_tail
            always_ff @(posedge clk) begin
                if (load) begin
                    slot_q[c] <= load_sums[c];
                end else if (busy_q) begin
                    slot_q[c] <= '0;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (load) begin
                    slot_q[c] <= load_sums[c];
                end else if (busy_q) begin
                    slot_q[c] <= slot_q[c+1];
                end
            end
        end
    end

    assign meas_valid = busy_q && mask_q[0];
    assign meas_data  = slot_q[0];
    assign meas_chan  = idx_q;
    assign meas_last  = meas_valid && ((mask_q >> 1) == '0);

    // R7: a new frame may only close once the previous one has drained
    a_r7_drain_done: assert property (@(posedge clk) disable iff (rst)
        (load && busy_q) |-> (idx_q == LAST_IDX));

    // R8: the end flag only marks a presented word
    a_r8_last_valid: assert property (@(posedge clk) disable iff (rst)
        meas_last |-> meas_valid);

    // R8: no word follows the end flag within a frame
    a_r8_last_final: assert property (@(posedge clk) disable iff (rst)
        (meas_last && !load) |=> !meas_valid);

    // R10: reset silences the output
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> !meas_valid);

endmodule

// File: rtl/cs_accum_bank.sv
`timescale 1ns/1ps
module cs_accum_bank
    import cs_accum_pkg::*;
#(
    parameter int          NUM_CH   = 25,
    parameter int          SAMPLE_W = 10,
    parameter int          ACC_W    = 13,
    parameter lfsr_state_t SEED     = LFSR_SEED_DEF,
    localparam int         LEN_W    = ACC_W - SAMPLE_W,
    localparam int         CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic [NUM_CH-1:0]   ch_enable,
    input  logic                mix_binary,
    output logic                meas_valid,
    output logic [ACC_W-1:0]    meas_data,
    output logic [CH_W-1:0]     meas_chan,
    output logic                meas_last
);

    frame_evt_t              evt;
    logic [NUM_CH-1:0]       mix_bits;
    logic signed [ACC_W-1:0] sums_nx [NUM_CH];
    mix_mode_e               mode;

    assign mode = mix_binary ? MIX_ZERO_ONE : MIX_PLUS_MINUS;

    cs_frame_ctrl #(
        .LEN_W (LEN_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .frame_len (frame_len),
        .evt       (evt)
    );

    cs_lfsr_bank #(
        .NUM_CH (NUM_CH),
        .SEED   (SEED)
    ) gen_i (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .mix_bits (mix_bits)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cs_accum_channel #(
            .SAMPLE_W (SAMPLE_W),
            .ACC_W    (ACC_W)
        ) ch_i (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt),
            .enable   (ch_enable[c]),
            .mix_bit  (mix_bits[c]),
            .mode     (mode),
            .sample   (smp_data),
            .sum_next (sums_nx[c])
        );
    end

    cs_meas_serializer #(
        .NUM_CH (NUM_CH),
        .ACC_W  (ACC_W),
        .CH_W   (CH_W)
    ) ser_i (
        .clk        (clk),
        .rst        (rst),
        .load       (evt.close),
        .load_mask  (ch_enable),
        .load_sums  (sums_nx),
        .meas_valid (meas_valid),
        .meas_data  (meas_data),
        .meas_chan  (meas_chan),
        .meas_last  (meas_last)
    );

endmodule

// File: tb/cs_accum_bank_tb_top.sv
`timescale 1ns/1ps
module cs_accum_bank_tb_top;

    localparam int NCH  = 6;
    localparam int SW   = 4;
    localparam int AW   = 7;
    localparam int LW   = AW - SW;
    localparam int CW   = $clog2(NCH);
    localparam logic [15:0] SEED = 16'hACE1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [LW-1:0] frame_len = LW'(1);
    logic [NCH-1:0] ch_enable = '0;
    logic          mix_binary = 1'b0;
    logic          meas_valid;
    logic [AW-1:0] meas_data;
    logic [CW-1:0] meas_chan;
    logic          meas_last;

    always #4 clk = ~clk;

    cs_accum_bank #(
        .NUM_CH (NCH), .SAMPLE_W (SW), .ACC_W (AW), .SEED (SEED)
    ) dut_i (
        .clk (clk), .rst (rst), .smp_valid (smp_valid), .smp_data (smp_data),
        .frame_len (frame_len), .ch_enable (ch_enable), .mix_binary (mix_binary),
        .meas_valid (meas_valid), .meas_data (meas_data),
        .meas_chan (meas_chan), .meas_last (meas_last)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // output capture
    int cap_val [16];
    int cap_ch  [16];
    bit cap_last[16];
    int cap_n = 0;

    always @(negedge clk) begin
        if (meas_valid && cap_n < 16) begin
            cap_val[cap_n]  = $signed(meas_data);
            cap_ch[cap_n]   = int'(meas_chan);
            cap_last[cap_n] = meas_last;
            cap_n++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // reference model
    logic [15:0] m_lfsr = SEED;
    int m_acc [NCH];
    int m_cnt = 0;
    int exp_val [NCH];
    int exp_ch  [NCH];
    int exp_n = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_lfsr = SEED;
        m_cnt  = 0;
        for (int c = 0; c < NCH; c++) m_acc[c] = 0;
    endtask

    // R5: generator stepped NCH times per sample, channel c takes step c+1
    task automatic model_sample(input int x, input logic [NCH-1:0] en,
                                input bit bm, input int len);
        for (int c = 0; c < NCH; c++) begin
            logic fb;
            fb = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10];
            m_lfsr = {m_lfsr[14:0], fb};
            if (en[c]) begin
                if (bm) m_acc[c] += fb ? x : 0;
                else    m_acc[c] += fb ? x : -x;
            end
        end
        m_cnt++;
        if (m_cnt == len) begin
            exp_n = 0;
            for (int c = 0; c < NCH; c++) begin
                if (en[c]) begin
                    exp_val[exp_n] = m_acc[c];
                    exp_ch[exp_n]  = c;
                    exp_n++;
                end
            end
            model_clear();
        end
    endtask

    task automatic drive_sample(input int x, input logic [NCH-1:0] en,
                                input bit bm, input int len);
        @(negedge clk);
        smp_valid  = 1'b1;
        smp_data   = SW'(x);
        ch_enable  = en;
        mix_binary = bm;
        frame_len  = LW'(len);
        model_sample(x, en, bm, len);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (NCH + 2) @(negedge clk);
    endtask

    int smp [8];

    task automatic run_frame(input int len, input bit bm, input logic [NCH-1:0] en_a,
                             input logic [NCH-1:0] en_b, input int switch_at,
                             input string req);
        cap_n = 0;
        for (int i = 0; i < len; i++)
            drive_sample(smp[i], (i < switch_at) ? en_a : en_b, bm, len);
        #1;
        chk(cap_n == exp_n, "R7", {req, " word count"}, cap_n, exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            chk(cap_val[k] == exp_val[k], req, "measurement", cap_val[k], exp_val[k]);
            chk(cap_ch[k] == exp_ch[k], "R7", "channel order", cap_ch[k], exp_ch[k]);
            chk(cap_last[k] == (k == exp_n - 1), "R8", "last flag",
                int'(cap_last[k]), int'(k == exp_n - 1));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        @(negedge clk);
        chk(!meas_valid, "R10", "valid during reset", int'(meas_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        chk(!meas_valid, "R10", "valid after reset", int'(meas_valid), 0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        do_reset();

        // R1 R3: largest positive samples, full frame
        for (int i = 0; i < 8; i++) smp[i] = 7;
        run_frame(7, 1'b0, '1, '1, 99, "R3");
        // R3: most negative samples
        for (int i = 0; i < 8; i++) smp[i] = -8;
        run_frame(7, 1'b0, '1, '1, 99, "R3");
        // R1 R5 R9: ramp, cleared sums and reseeded generator
        for (int i = 0; i < 8; i++) smp[i] = ((i * 5 + 3) % 16) - 8;
        run_frame(5, 1'b0, '1, '1, 99, "R1");
        run_frame(5, 1'b0, '1, '1, 99, "R9");
        // R2: binary mixing, ramp and extreme values
        run_frame(6, 1'b1, '1, '1, 99, "R2");
        for (int i = 0; i < 8; i++) smp[i] = -8;
        run_frame(7, 1'b1, '1, '1, 99, "R2");
        // R4: sparse mask
        for (int i = 0; i < 8; i++) smp[i] = ((i * 3 + 1) % 16) - 8;
        run_frame(4, 1'b0, 6'b101001, 6'b101001, 99, "R4");
        // R4: mask narrowed in the middle of a frame
        run_frame(7, 1'b0, 6'b111111, 6'b010110, 3, "R4");
        // R4: all channels off, no output
        run_frame(3, 1'b0, '0, '0, 99, "R4");
        // R7: one-sample frame
        smp[0] = 5;
        run_frame(1, 1'b0, '1, '1, 99, "R7");
        // R6 R10: reset in mid-frame, then a full frame from the seed
        for (int i = 0; i < 8; i++) smp[i] = ((i * 7 + 2) % 16) - 8;
        for (int i = 0; i < 3; i++) drive_sample(smp[i], '1, 1'b0, 7);
        do_reset();
        run_frame(7, 1'b0, '1, '1, 99, "R6");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule